// File: doc/BRIEF.md
# Mixed-Direction GPIO Port with LED Modulator

This block is a 4-pin general-purpose I/O port that sits on a small microcontroller's byte-wide I/O bus. Pins 0, 1 and 3 are bidirectional. Each of them can be an input with or without a pull-up, or a push-pull output. Pin 2 is a dedicated LED driver and always drives. Its level comes from a modulator flip-flop. A timer overflow strobe can set, clear or toggle that flip-flop, or, with modulation off, the flip-flop copies the data latch.

Software uses three byte addresses. The data latch at 0x1B holds the output levels and pull-up selects. The control register at 0x1A holds the direction bits of the bidirectional pins, and its bit 2 enables pin 2's high-current driver. The read-only sample address at 0x19 returns the synchronized pin levels. The pad-facing outputs pass through one extra register stage, so every change reaches the pads one clock later than it reaches the registers. Asserting reset releases the bidirectional pins at once, without waiting for a clock edge.

Top module: `gpio_mixport`

## Requirements
- R1: A write strobe with address 0x1B loads the data latch, and one with 0x1A loads the control register. A read strobe returns that register's contents on `bus_rdata` in the cycle after the strobe. When no read was strobed in the previous cycle, `bus_rdata` is 0.
- R2: Bits 7..4 of the data latch and of the control register always read 0, and writing ones to them has no effect.
- R3: After reset the data latch reads 0x04 and the control register reads 0x00. `pad_out[2]` is 1, `pad_pu` is 0 and `pad2_hc` is 0.
- R4: For each bidirectional pin n in {0,1,3}, with direction bit d = control bit n and latch bit l = data bit n: `pad_oe[n]` = d, `pad_out[n]` = d AND l, and `pad_pu[n]` = (NOT d) AND l. A pin is therefore never driven and pulled up at the same time.
- R5: Pin 2 always has `pad_oe[2]` = 1 and `pad_pu[2]` = 0. Control bit 2 sets no direction. It drives `pad2_hc`.
- R6: A read of 0x19 returns the pad inputs of pins 0, 1 and 3 at bits 0, 1 and 3, through a two-flop synchronizer. A level applied before clock edge k is returned by a read strobed at edge k+2 but not by one strobed at edge k+1. Bits 2 and 7..4 read 0, and writes to 0x19 change neither register.
- R7: A register write taken at clock edge k changes `pad_oe`, `pad_out`, `pad_pu` and `pad2_hc` at edge k+1, not at edge k.
- R8: While `rst` is 1, `pad_oe` and `pad_pu` of pins 0, 1 and 3 are 0, even if no clock edge has occurred.
- R9: With `mod_mode` = 00, `pad_out[2]` follows data latch bit 2 with the R7 delay, and `tmr_ovf` has no effect.
- R10: With `mod_mode` = 01, each cycle with `tmr_ovf` = 1 inverts `pad_out[2]` at that clock edge.
- R11: With `mod_mode` = 10, a `tmr_ovf` strobe clears `pad_out[2]`. With 11 it sets it. In modes 01, 10 and 11, `pad_out[2]` holds in any cycle without a strobe.
- R12: Reads of any address other than 0x19, 0x1A and 0x1B return 0. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset. Synchronous for the registers, immediate for pin release |
| bus_addr | input | 8 | I/O address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| pad_in | input | 4 | Raw pad input levels |
| pad_oe | output | 4 | Per-pin output enable |
| pad_out | output | 4 | Per-pin output value |
| pad_pu | output | 4 | Per-pin pull-up enable |
| pad2_hc | output | 1 | High-current driver enable for pin 2 |
| mod_mode | input | 2 | Modulator mode: 00 off, 01 toggle, 10 clear, 11 set |
| tmr_ovf | input | 1 | Single-cycle timer overflow strobe |

## Verification
The bench sweeps all 256 combinations of direction and latch nibbles and compares every pad signal against the R4 truth table. A design that swapped the pull-up and output-value terms, or let control bit 2 act as a direction bit, fails there. It checks the extra output cycle and the two-flop input latency by sampling one edge early as well as on time. A design missing the output register, or with one synchronizer stage too few, fails at the early sample. It pulses reset between clock edges to catch a design that releases the pins only on an edge. It steps the modulator through all four modes, with and without strobes, to catch a design that toggles in the wrong mode or reacts to strobes while modulation is off.

// File: rtl/gpio_mixport_pkg.sv
package gpio_mixport_pkg;

  typedef enum logic [1:0] {
    MOD_OFF    = 2'b00,
    MOD_TOGGLE = 2'b01,
    MOD_CLEAR  = 2'b10,
    MOD_SET    = 2'b11
  } mod_mode_e;

endpackage

// File: rtl/gpio_mixport_sync.sv
module gpio_mixport_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_mixport_regs.sv
module gpio_mixport_regs #(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter int              PORT_W    = 4,
  parameter int              OUT_PIN   = 2,
  parameter logic [ADDR_W-1:0] ADDR_DATA = 8'h1B,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 8'h1A,
  parameter logic [ADDR_W-1:0] ADDR_PIN  = 8'h19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PORT_W-1:0] pin_sync,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] rdata
);

  localparam int              PAD_W     = DATA_W - PORT_W;
  localparam logic [PORT_W-1:0] OUT_MASK  = PORT_W'(1) << OUT_PIN;
  localparam logic [PORT_W-1:0] LATCH_RST = OUT_MASK;

  logic              sel_data;
  logic              sel_ctrl;
  logic              sel_pin;
  logic [PORT_W-1:0] rd_nib;
  logic              unused_wdata_hi;

  assign sel_data        = (addr == ADDR_DATA);
  assign sel_ctrl        = (addr == ADDR_CTRL);
  assign sel_pin         = (addr == ADDR_PIN);
  assign unused_wdata_hi = ^wdata[DATA_W-1:PORT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= LATCH_RST;
      ctrl_q  <= '0;
    end else if (wr) begin
      if (sel_data) latch_q <= wdata[PORT_W-1:0];
      if (sel_ctrl) ctrl_q  <= wdata[PORT_W-1:0];
    end
  end

  always_comb begin
    rd_nib = '0;
    if (sel_data)      rd_nib = latch_q;
    else if (sel_ctrl) rd_nib = ctrl_q;
    else if (sel_pin)  rd_nib = pin_sync & ~OUT_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= {{PAD_W{1'b0}}, rd_nib};
    else         rdata <= '0;
  end

endmodule

// File: rtl/gpio_mixport_bidir.sv
module gpio_mixport_bidir (
  input  logic clk,
  input  logic rst,
  input  logic dir,
  input  logic latch,
  output logic oe,
  output logic out,
  output logic pu
);

  logic oe_q;
  logic out_q;
  logic pu_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      out_q <= 1'b0;
      pu_q  <= 1'b0;
    end else begin
      oe_q  <= dir;
      out_q <= dir & latch;
      pu_q  <= ~dir & latch;
    end
  end

  // release the pad as soon as reset rises, clock or not
  assign oe  = oe_q & ~rst;
  assign pu  = pu_q & ~rst;
  assign out = out_q;

endmodule

// File: rtl/gpio_mixport_mod.sv
module gpio_mixport_mod
  import gpio_mixport_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       ovf,
  input  logic       latch_bit,
  output logic       q
);

  mod_mode_e mode_e;
  assign mode_e = mod_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b1;
    end else begin
      unique case (mode_e)
        MOD_OFF:    q <= latch_bit;
        MOD_TOGGLE: if (ovf) q <= ~q;
        MOD_CLEAR:  if (ovf) q <= 1'b0;
        MOD_SET:    if (ovf) q <= 1'b1;
        default:    q <= q;
      endcase
    end
  end

endmodule

// File: rtl/gpio_mixport.sv
module gpio_mixport #(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter int              PORT_W    = 4,
  parameter int              OUT_PIN   = 2,
  parameter int              SYNC_LEN  = 2,
  parameter logic [ADDR_W-1:0] ADDR_DATA = 8'h1B,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 8'h1A,
  parameter logic [ADDR_W-1:0] ADDR_PIN  = 8'h19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_pu,
  output logic              pad2_hc,
  input  logic [1:0]        mod_mode,
  input  logic              tmr_ovf
);

  logic [PORT_W-1:0] pin_sync;
  logic [PORT_W-1:0] latch_q;
  logic [PORT_W-1:0] ctrl_q;
  logic              mod_q;
  logic              hc_q;

  gpio_mixport_sync #(
    .WIDTH  (PORT_W),
    .STAGES (SYNC_LEN)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pad_in),
    .dout (pin_sync)
  );

  gpio_mixport_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PORT_W    (PORT_W),
    .OUT_PIN   (OUT_PIN),
    .ADDR_DATA (ADDR_DATA),
    .ADDR_CTRL (ADDR_CTRL),
    .ADDR_PIN  (ADDR_PIN)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .wdata    (bus_wdata),
    .pin_sync (pin_sync),
    .latch_q  (latch_q),
    .ctrl_q   (ctrl_q),
    .rdata    (bus_rdata)
  );

  gpio_mixport_mod u_mod (
    .clk       (clk),
    .rst       (rst),
    .mode      (mod_mode),
    .ovf       (tmr_ovf),
    .latch_bit (latch_q[OUT_PIN]),
    .q         (mod_q)
  );

  // high-current enable shares the extra output stage
  always_ff @(posedge clk) begin
    if (rst) hc_q <= 1'b0;
    else     hc_q <= ctrl_q[OUT_PIN];
  end
  assign pad2_hc = hc_q;

  for (genvar n = 0; n < PORT_W; n++) begin : g_pin
    if (n == OUT_PIN) begin : g_led
      assign pad_oe[n]  = 1'b1;
      assign pad_out[n] = mod_q;
      assign pad_pu[n]  = 1'b0;
    end else begin : g_io
      gpio_mixport_bidir u_pin (
        .clk   (clk),
        .rst   (rst),
        .dir   (ctrl_q[n]),
        .latch (latch_q[n]),
        .oe    (pad_oe[n]),
        .out   (pad_out[n]),
        .pu    (pad_pu[n])
      );
    end
  end

endmodule

// File: rtl/gpio_mixport_chk.sv
module gpio_mixport_chk #(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter int              PORT_W    = 4,
  parameter int              OUT_PIN   = 2,
  parameter logic [ADDR_W-1:0] ADDR_DATA = 8'h1B,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 8'h1A,
  parameter logic [ADDR_W-1:0] ADDR_PIN  = 8'h19
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PORT_W-1:0] pad_oe,
  input logic [PORT_W-1:0] pad_out,
  input logic [PORT_W-1:0] pad_pu,
  input logic [1:0]        mod_mode,
  input logic              tmr_ovf
);

  localparam logic [PORT_W-1:0] BIDIR = ~(PORT_W'(1) << OUT_PIN);

  logic decoded;
  assign decoded = (bus_addr == ADDR_DATA) || (bus_addr == ADDR_CTRL) || (bus_addr == ADDR_PIN);

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst) !bus_rd |=> (bus_rdata == '0)); // R1
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst) bus_rdata[DATA_W-1:PORT_W] == '0); // R2
  AST_NO_DRIVE_AND_PULL: assert property (@(posedge clk) disable iff (rst) (pad_oe & pad_pu) == '0); // R4
  AST_RESET_RELEASE: assert property (@(posedge clk) rst |-> ((pad_oe & BIDIR) == '0 && (pad_pu & BIDIR) == '0)); // R8
  AST_TOGGLE: assert property (@(posedge clk) disable iff (rst) (mod_mode == 2'b01 && tmr_ovf) |=> (pad_out[OUT_PIN] != $past(pad_out[OUT_PIN]))); // R10
  AST_CLEAR: assert property (@(posedge clk) disable iff (rst) (mod_mode == 2'b10 && tmr_ovf) |=> !pad_out[OUT_PIN]); // R11
  AST_SET: assert property (@(posedge clk) disable iff (rst) (mod_mode == 2'b11 && tmr_ovf) |=> pad_out[OUT_PIN]); // R11
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) (mod_mode != 2'b00 && !tmr_ovf) |=> $stable(pad_out[OUT_PIN])); // R11
  AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (rst) (bus_rd && !decoded) |=> (bus_rdata == '0)); // R12

endmodule

bind gpio_mixport gpio_mixport_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PORT_W    (PORT_W),
  .OUT_PIN   (OUT_PIN),
  .ADDR_DATA (ADDR_DATA),
  .ADDR_CTRL (ADDR_CTRL),
  .ADDR_PIN  (ADDR_PIN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .pad_pu    (pad_pu),
  .mod_mode  (mod_mode),
  .tmr_ovf   (tmr_ovf)
);

// File: tb/gpio_mixport_bench.sv
module gpio_mixport_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] pad_in = '0;
  logic [3:0] pad_oe;
  logic [3:0] pad_out;
  logic [3:0] pad_pu;
  logic       pad2_hc;
  logic [1:0] mod_mode = 2'b00;
  logic       tmr_ovf = 1'b0;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  gpio_mixport u_gpio_mixport (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu    (pad_pu),
    .pad2_hc   (pad2_hc),
    .mod_mode  (mod_mode),
    .tmr_ovf   (tmr_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_ovf();
    @(negedge clk);
    tmr_ovf = 1'b1;
    @(negedge clk);
    tmr_ovf = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    logic [3:0] exp_oe, exp_out, exp_pu;

    // R8: released with reset high before any clock edge
    #1;
    chk("R8 oe before clock", {28'd0, pad_oe & 4'b1011}, 32'd0);
    chk("R8 pu before clock", {28'd0, pad_pu & 4'b1011}, 32'd0);
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);

    // R3 reset state
    chk("R3 pad_out2", {31'd0, pad_out[2]}, 32'd1);
    chk("R3 pad_pu", {28'd0, pad_pu}, 32'd0);
    chk("R3 hc", {31'd0, pad2_hc}, 32'd0);
    bus_read(8'h1B, rv); chk("R3 data reset", {24'd0, rv}, 32'h04);
    bus_read(8'h1A, rv); chk("R3 ctrl reset", {24'd0, rv}, 32'h00);
    wait_cyc(1);
    chk("R1 rdata idle zero", {24'd0, bus_rdata}, 32'd0);

    // R4 R5 R2 R1: full sweep of direction and latch
    for (int d = 0; d < 16; d++) begin
      for (int l = 0; l < 16; l++) begin
        bus_write(8'h1A, {4'hA, 4'(d)});
        bus_write(8'h1B, {4'h5, 4'(l)});
        wait_cyc(1);
        exp_oe  = (4'(d) & 4'b1011) | 4'b0100;
        exp_out = (4'(d) & 4'(l) & 4'b1011) | (4'(l) & 4'b0100);
        exp_pu  = ~4'(d) & 4'(l) & 4'b1011;
        chk("R4 R5 pad_oe", {28'd0, pad_oe}, {28'd0, exp_oe});
        chk("R4 R9 pad_out", {28'd0, pad_out}, {28'd0, exp_out});
        chk("R4 R5 pad_pu", {28'd0, pad_pu}, {28'd0, exp_pu});
        chk("R5 hc", {31'd0, pad2_hc}, {31'd0, 1'((d >> 2) & 1)});
        if (l == d || l == 15 - d) begin
          bus_read(8'h1B, rv); chk("R1 R2 data readback", {24'd0, rv}, 32'(l));
          bus_read(8'h1A, rv); chk("R1 R2 ctrl readback", {24'd0, rv}, 32'(d));
        end
      end
    end

    // R7: output stage adds one cycle
    bus_write(8'h1A, 8'h0B);
    bus_write(8'h1B, 8'h00);
    wait_cyc(2);
    bus_write(8'h1B, 8'h0F);
    chk("R7 one edge after write", {28'd0, pad_out}, 32'h0);
    wait_cyc(1);
    chk("R7 two edges after write", {28'd0, pad_out}, 32'hF);
    bus_write(8'h1A, 8'h00);
    chk("R7 oe one edge after write", {28'd0, pad_oe}, 32'hF);
    wait_cyc(1);
    chk("R7 oe two edges after write", {28'd0, pad_oe}, 32'h4);

    // R6: pin sample path, all input patterns
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      pad_in = ~4'(p);
      wait_cyc(3);
      @(negedge clk);
      pad_in = 4'(p);
      bus_read(8'h19, rv);
      chk("R6 early read old", {24'd0, rv}, {28'd0, ~4'(p) & 4'b1011});
      bus_read(8'h19, rv);
      chk("R6 sync value", {24'd0, rv}, {28'd0, 4'(p) & 4'b1011});
    end
    bus_write(8'h1B, 8'h09);
    bus_write(8'h1A, 8'h02);
    bus_write(8'h19, 8'hFF);
    bus_read(8'h1B, rv); chk("R6 pin write ignored data", {24'd0, rv}, 32'h09);
    bus_read(8'h1A, rv); chk("R6 pin write ignored ctrl", {24'd0, rv}, 32'h02);

    // R12: undecoded addresses
    bus_write(8'h1C, 8'hFF);
    bus_write(8'h00, 8'hFF);
    bus_read(8'h1B, rv); chk("R12 data unchanged", {24'd0, rv}, 32'h09);
    bus_read(8'h1A, rv); chk("R12 ctrl unchanged", {24'd0, rv}, 32'h02);
    bus_read(8'h1C, rv); chk("R12 read 0x1C", {24'd0, rv}, 32'h0);
    bus_read(8'hFF, rv); chk("R12 read 0xFF", {24'd0, rv}, 32'h0);
    bus_read(8'h18, rv); chk("R12 read 0x18", {24'd0, rv}, 32'h0);

    // R9: mode off follows latch, ignores strobes
    mod_mode = 2'b00;
    bus_write(8'h1B, 8'h04);
    wait_cyc(1);
    chk("R9 follows latch 1", {31'd0, pad_out[2]}, 32'd1);
    pulse_ovf();
    wait_cyc(1);
    chk("R9 strobe ignored", {31'd0, pad_out[2]}, 32'd1);
    bus_write(8'h1B, 8'h00);
    chk("R9 R7 not yet", {31'd0, pad_out[2]}, 32'd1);
    wait_cyc(1);
    chk("R9 follows latch 0", {31'd0, pad_out[2]}, 32'd0);
    bus_write(8'h1B, 8'h04);
    wait_cyc(1);

    // R10 R11: modulation modes
    @(negedge clk); mod_mode = 2'b01;
    wait_cyc(3);
    chk("R11 hold in toggle", {31'd0, pad_out[2]}, 32'd1);
    pulse_ovf();
    chk("R10 toggle to 0", {31'd0, pad_out[2]}, 32'd0);
    pulse_ovf();
    chk("R10 toggle to 1", {31'd0, pad_out[2]}, 32'd1);
    @(negedge clk); mod_mode = 2'b10;
    pulse_ovf();
    chk("R11 clear", {31'd0, pad_out[2]}, 32'd0);
    pulse_ovf();
    chk("R11 clear again", {31'd0, pad_out[2]}, 32'd0);
    @(negedge clk); mod_mode = 2'b11;
    wait_cyc(2);
    chk("R11 hold in set mode", {31'd0, pad_out[2]}, 32'd0);
    pulse_ovf();
    chk("R11 set", {31'd0, pad_out[2]}, 32'd1);
    @(negedge clk); mod_mode = 2'b10;
    wait_cyc(3);
    chk("R11 hold in clear mode", {31'd0, pad_out[2]}, 32'd1);
    bus_write(8'h1B, 8'h00);
    wait_cyc(1);
    chk("R11 latch ignored while modulating", {31'd0, pad_out[2]}, 32'd1);
    @(negedge clk); mod_mode = 2'b00;
    wait_cyc(1);
    chk("R9 back to latch", {31'd0, pad_out[2]}, 32'd0);

    // R8: reset between edges releases pins at once
    bus_write(8'h1A, 8'h0B);
    bus_write(8'h1B, 8'h0B);
    wait_cyc(1);
    chk("R8 pins driving first", {28'd0, pad_oe}, 32'hF);
    #1;
    rst = 1'b1;
    #0.5;
    chk("R8 oe released without edge", {28'd0, pad_oe & 4'b1011}, 32'd0);
    chk("R8 pu released without edge", {28'd0, pad_pu & 4'b1011}, 32'd0);
    wait_cyc(2);
    rst = 1'b0;
    bus_read(8'h1B, rv); chk("R3 data after reset", {24'd0, rv}, 32'h04);
    bus_read(8'h1A, rv); chk("R3 ctrl after reset", {24'd0, rv}, 32'h00);
    chk("R3 pad_out2 after reset", {31'd0, pad_out[2]}, 32'd1);

    finish_run();
  end

endmodule